// File: doc/BRIEF.md
# Read-Protection Level Controller

This block holds the read-protection level of an embedded flash and enforces it. After reset it decodes the stored protection byte into one of three levels: open, guarded or locked. It then accepts requests to move to a new level, each given as a new protection-byte value. Raising the level takes effect at once. Leaving the guarded level for the open level first starts a mass erase of main flash and backup SRAM. The new level is committed only when the external erase engine reports completion. The locked level cannot be left.

Alongside the level state, the block answers access requests with a combinational grant. The grant depends on the memory area, the operation and the execution context: either the part runs from user flash, or it runs with debug attached, from RAM or from the system bootloader. It also drives the enables for the debug port and for system-memory boot. The flash array, the option-byte programming and the erase timing all live outside the block.

Top module: `rdp_guard`

## Requirements
- R1: Byte 0xAA decodes to level code 0 (open), 0xCC to level code 2 (locked), and every other byte to level code 1 (guarded). `level_o` reads 1 while reset is active and holds the decoded `opt_byte_i` from the first cycle after the synchronised reset release.
- R2: At level 2, every change request is refused. `chg_err_o` pulses for exactly one cycle and `level_o` stays 2.
- R3: A request for level 0 at level 1 gives a one-cycle `erase_start_o` pulse and raises `erase_busy_o`, and `level_o` stays 1. The cycle after `erase_done_i` is sampled high, `level_o` becomes 0 and `erase_busy_o` clears.
- R4: A raise (0 to 1, 1 to 2 or 0 to 2) is visible on `level_o` one cycle after the request, with no `erase_start_o` pulse and no `chg_err_o`.
- R5: While `erase_busy_o` is high, change requests are ignored: no error, no second erase pulse and no level change.
- R6: `debug_en_o` and `sysboot_en_o` are low at level 2 and high at levels 0 and 1.
- R7: Operation codes are 0 read, 1 write, 2 erase and 3 reserved (always denied). Area codes are 0 main flash, 1 backup SRAM, 2 option bytes and 3 OTP. For main flash and backup SRAM, read, write and erase are granted when `ctx_flash_i` is 1 (boot from user flash) at any level, and otherwise only at level 0.
- R8: For option bytes, read and write are granted at levels 0 and 1 and denied at level 2, in either context. Erase is always denied.
- R9: For OTP, write and erase are always denied. Read is granted at level 0, or when `ctx_flash_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opt_byte_i | input | 8 | Stored protection byte, loaded after reset |
| chg_req_i | input | 1 | Level-change request strobe |
| chg_byte_i | input | 8 | Requested protection byte |
| erase_done_i | input | 1 | Mass erase finished |
| ctx_flash_i | input | 1 | 1 = running from user flash, 0 = debug, RAM or bootloader |
| acc_area_i | input | 2 | Access area code |
| acc_op_i | input | 2 | Access operation code |
| acc_grant_o | output | 1 | Access granted |
| level_o | output | 2 | Current level code |
| debug_en_o | output | 1 | Debug and trace port enable |
| sysboot_en_o | output | 1 | System-memory boot enable |
| erase_start_o | output | 1 | One-cycle mass-erase start |
| erase_busy_o | output | 1 | Mass erase in progress |
| chg_err_o | output | 1 | One-cycle illegal-request pulse |

## Verification
A wrong level register shows up on `level_o`, and in the same cycle on the grant and debug-enable outputs, because those decode the register without delay. A misplaced erase state shows one cycle after the request, either as a missing or extra `erase_start_o` or as `erase_busy_o` in the wrong state. It also shows as a level commit that arrives before `erase_done_i`. Every grant is combinational, so a wrong table entry is visible in the same cycle as the access inputs change.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic [1:0] {LVL_OPEN = 2'd0, LVL_GUARD = 2'd1, LVL_LOCK = 2'd2} lvl_e;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_ER = 2'd2, OP_RSV = 2'd3} op_e;
  typedef enum logic [1:0] {AR_MAIN = 2'd0, AR_BKP = 2'd1, AR_OPT = 2'd2, AR_OTP = 2'd3} area_e;
  typedef enum logic [1:0] {ST_LOAD = 2'd0, ST_RUN = 2'd1, ST_ERASE = 2'd2} st_e;
endpackage

// File: rtl/rdp_rst_sync.sv
module rdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = pipe_q[STAGES-1];
endmodule

// File: rtl/rdp_decode.sv
module rdp_decode
  import rdp_pkg::*;
#(
  parameter int           W         = 8,
  parameter logic [W-1:0] OPEN_CODE = 8'hAA,
  parameter logic [W-1:0] LOCK_CODE = 8'hCC
) (
  input  logic [W-1:0] byte_i,
  output lvl_e         lvl_o
);
  always_comb begin
    if (byte_i == OPEN_CODE)      lvl_o = LVL_OPEN;
    else if (byte_i == LOCK_CODE) lvl_o = LVL_LOCK;
    else                          lvl_o = LVL_GUARD;
  end
endmodule

// File: rtl/rdp_fsm.sv
module rdp_fsm
  import rdp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_e boot_lvl_i,
  input  logic req_i,
  input  lvl_e req_lvl_i,
  input  logic erase_done_i,
  output lvl_e lvl_o,
  output logic busy_o,
  output logic erase_start_o,
  output logic err_o
);
  st_e  st_q, st_d;
  lvl_e lvl_q, lvl_d;
  logic lvl_we;
  logic err_d, ers_d;

  always_comb begin
    st_d   = st_q;
    lvl_d  = lvl_q;
    lvl_we = 1'b0;
    err_d  = 1'b0;
    ers_d  = 1'b0;
    unique case (st_q)
      ST_LOAD: begin
        lvl_d  = boot_lvl_i;
        lvl_we = 1'b1;
        st_d   = ST_RUN;
      end
      ST_RUN: begin
        if (req_i) begin
          if (lvl_q == LVL_LOCK) begin
            err_d = 1'b1;
          end else if (lvl_q == LVL_GUARD && req_lvl_i == LVL_OPEN) begin
            ers_d = 1'b1;
            st_d  = ST_ERASE;
          end else if (req_lvl_i >= lvl_q) begin
            lvl_d  = req_lvl_i;
            lvl_we = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_ERASE: begin
        if (erase_done_i) begin
          lvl_d  = LVL_OPEN;
          lvl_we = 1'b1;
          st_d   = ST_RUN;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_LOAD;
      lvl_q         <= LVL_GUARD;
      err_o         <= 1'b0;
      erase_start_o <= 1'b0;
    end else begin
      st_q          <= st_d;
      if (lvl_we) lvl_q <= lvl_d;
      err_o         <= err_d;
      erase_start_o <= ers_d;
    end
  end

  assign lvl_o  = lvl_q;
  assign busy_o = (st_q == ST_ERASE);
endmodule

// File: rtl/rdp_access.sv
module rdp_access
  import rdp_pkg::*;
(
  input  lvl_e        lvl_i,
  input  logic        ctx_flash_i,
  input  logic [1:0]  area_i,
  input  logic [1:0]  op_i,
  output logic        grant_o
);
  logic is_rd, is_wr, is_er, open_or_flash;

  always_comb begin
    is_rd         = (op_i == OP_RD);
    is_wr         = (op_i == OP_WR);
    is_er         = (op_i == OP_ER);
    open_or_flash = ctx_flash_i || (lvl_i == LVL_OPEN);
    unique case (area_i)
      AR_MAIN, AR_BKP: grant_o = (is_rd || is_wr || is_er) && open_or_flash;
      AR_OPT:          grant_o = (is_rd || is_wr) && (lvl_i != LVL_LOCK);
      default:         grant_o = is_rd && open_or_flash;
    endcase
  end
endmodule

// File: rtl/rdp_guard.sv
module rdp_guard
  import rdp_pkg::*;
#(
  parameter int                 BYTE_W      = 8,
  parameter logic [BYTE_W-1:0]  OPEN_CODE   = 8'hAA,
  parameter logic [BYTE_W-1:0]  LOCK_CODE   = 8'hCC,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] opt_byte_i,
  input  logic              chg_req_i,
  input  logic [BYTE_W-1:0] chg_byte_i,
  input  logic              erase_done_i,
  input  logic              ctx_flash_i,
  input  logic [1:0]        acc_area_i,
  input  logic [1:0]        acc_op_i,
  output logic              acc_grant_o,
  output logic [1:0]        level_o,
  output logic              debug_en_o,
  output logic              sysboot_en_o,
  output logic              erase_start_o,
  output logic              erase_busy_o,
  output logic              chg_err_o
);
  logic rst_sync_n;
  lvl_e boot_lvl, req_lvl, cur_lvl;

  rdp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_sync_n)
  );

  rdp_decode #(.W(BYTE_W), .OPEN_CODE(OPEN_CODE), .LOCK_CODE(LOCK_CODE)) u_dec_boot (
    .byte_i(opt_byte_i), .lvl_o(boot_lvl)
  );

  rdp_decode #(.W(BYTE_W), .OPEN_CODE(OPEN_CODE), .LOCK_CODE(LOCK_CODE)) u_dec_req (
    .byte_i(chg_byte_i), .lvl_o(req_lvl)
  );

  rdp_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .boot_lvl_i(boot_lvl),
    .req_i(chg_req_i), .req_lvl_i(req_lvl), .erase_done_i(erase_done_i),
    .lvl_o(cur_lvl), .busy_o(erase_busy_o), .erase_start_o(erase_start_o),
    .err_o(chg_err_o)
  );

  rdp_access u_acc (
    .lvl_i(cur_lvl), .ctx_flash_i(ctx_flash_i), .area_i(acc_area_i),
    .op_i(acc_op_i), .grant_o(acc_grant_o)
  );

  assign level_o      = cur_lvl;
  assign debug_en_o   = (cur_lvl != LVL_LOCK);
  assign sysboot_en_o = (cur_lvl != LVL_LOCK);
endmodule

// File: rtl/rdp_guard_chk.sv
module rdp_guard_chk (
  input logic       clk_i,
  input logic       rst_n,
  input logic [1:0] level,
  input logic       busy,
  input logic       erase_start,
  input logic       err,
  input logic       debug_en,
  input logic [1:0] area,
  input logic [1:0] op,
  input logic       grant
);
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    level == 2'd2 |=> level == 2'd2); // R2

  AST_ERR_KEEPS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_n)
    err |-> level == $past(level)); // R2

  AST_ERASE_FROM_GUARD: assert property (@(posedge clk_i) disable iff (!rst_n)
    erase_start |-> (level == 2'd1 && busy)); // R3

  AST_BUSY_HOLDS_GUARD: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy |-> level == 2'd1); // R5

  AST_NO_ERASE_ON_RAISE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (level != $past(level) && $past(level) != 2'd1) |-> !erase_start); // R4

  AST_DEBUG_OFF_LOCK: assert property (@(posedge clk_i) disable iff (!rst_n)
    level == 2'd2 |-> !debug_en); // R6

  AST_OTP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (area == 2'd3 && op != 2'd0) |-> !grant); // R9
endmodule

bind rdp_guard rdp_guard_chk u_chk (
  .clk_i(clk_i), .rst_n(rst_sync_n), .level(level_o), .busy(erase_busy_o),
  .erase_start(erase_start_o), .err(chg_err_o), .debug_en(debug_en_o),
  .area(acc_area_i), .op(acc_op_i), .grant(acc_grant_o)
);

// File: tb/rdp_guard_tb_top.sv
module rdp_guard_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] opt_byte_i, chg_byte_i;
  logic       chg_req_i, erase_done_i, ctx_flash_i;
  logic [1:0] acc_area_i, acc_op_i;
  logic       acc_grant_o, debug_en_o, sysboot_en_o, erase_start_o, erase_busy_o, chg_err_o;
  logic [1:0] level_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  rdp_guard dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .opt_byte_i(opt_byte_i), .chg_req_i(chg_req_i),
    .chg_byte_i(chg_byte_i), .erase_done_i(erase_done_i), .ctx_flash_i(ctx_flash_i),
    .acc_area_i(acc_area_i), .acc_op_i(acc_op_i), .acc_grant_o(acc_grant_o),
    .level_o(level_o), .debug_en_o(debug_en_o), .sysboot_en_o(sysboot_en_o),
    .erase_start_o(erase_start_o), .erase_busy_o(erase_busy_o), .chg_err_o(chg_err_o)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int decode_ref(logic [7:0] b);
    if (b == 8'hAA) return 0;
    if (b == 8'hCC) return 2;
    return 1;
  endfunction

  function automatic int grant_ref(int lvl, bit ctx, int area, int op);
    if (area <= 1) return (op != 3) && (ctx || lvl == 0);
    if (area == 2) return (op == 0 || op == 1) && lvl != 2;
    return (op == 0) && (ctx || lvl == 0);
  endfunction

  task automatic do_reset(logic [7:0] b, bit chk_rst);
    @(negedge clk_i);
    rst_ni = 1'b0;
    opt_byte_i = b;
    @(negedge clk_i);
    if (chk_rst) begin
      check("R1 reset level", level_o, 1);
      check("R3 reset busy", erase_busy_o, 0);
      check("R2 reset err", chg_err_o, 0);
      check("R3 reset erase", erase_start_o, 0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
  endtask

  task automatic request(logic [7:0] b);
    chg_req_i  = 1'b1;
    chg_byte_i = b;
    @(negedge clk_i);
    chg_req_i  = 1'b0;
  endtask

  task automatic t_decode();
    logic [7:0] vals [4] = '{8'hAA, 8'hCC, 8'h55, 8'h00};
    foreach (vals[i]) begin
      do_reset(vals[i], i == 0);
      check("R1 decode", level_o, decode_ref(vals[i]));
    end
  endtask

  task automatic t_lock_refuse();
    do_reset(8'hCC, 0);
    request(8'hAA);
    check("R2 err pulse", chg_err_o, 1);
    check("R2 level kept", level_o, 2);
    check("R2 no erase", erase_start_o, 0);
    @(negedge clk_i);
    check("R2 err one cycle", chg_err_o, 0);
    request(8'h00);
    check("R2 err to 1", chg_err_o, 1);
    check("R2 level kept 1", level_o, 2);
    @(negedge clk_i);
  endtask

  task automatic t_raise();
    do_reset(8'hAA, 0);
    request(8'h55);
    check("R4 0to1 level", level_o, 1);
    check("R4 0to1 erase", erase_start_o, 0);
    check("R4 0to1 err", chg_err_o, 0);
    request(8'hCC);
    check("R4 1to2 level", level_o, 2);
    check("R4 1to2 erase", erase_start_o, 0);
    do_reset(8'hAA, 0);
    request(8'hCC);
    check("R4 0to2 level", level_o, 2);
    check("R4 0to2 erase", erase_start_o, 0);
    check("R4 0to2 err", chg_err_o, 0);
  endtask

  task automatic t_erase();
    do_reset(8'h00, 0);
    request(8'hAA);
    check("R3 erase pulse", erase_start_o, 1);
    check("R3 busy", erase_busy_o, 1);
    check("R3 level held", level_o, 1);
    @(negedge clk_i);
    check("R3 pulse one cycle", erase_start_o, 0);
    request(8'hCC);
    check("R5 busy no err", chg_err_o, 0);
    check("R5 busy no level", level_o, 1);
    check("R5 busy no erase", erase_start_o, 0);
    request(8'hAA);
    check("R5 busy no second erase", erase_start_o, 0);
    check("R5 still busy", erase_busy_o, 1);
    erase_done_i = 1'b1;
    @(negedge clk_i);
    erase_done_i = 1'b0;
    check("R3 commit level", level_o, 0);
    check("R3 busy clear", erase_busy_o, 0);
  endtask

  task automatic t_grants();
    logic [7:0] vals [3] = '{8'hAA, 8'h00, 8'hCC};
    foreach (vals[i]) begin
      do_reset(vals[i], 0);
      check("R6 debug_en", debug_en_o, i != 2);
      check("R6 sysboot_en", sysboot_en_o, i != 2);
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 4; a++)
          for (int o = 0; o < 4; o++) begin
            ctx_flash_i = c[0];
            acc_area_i  = a[1:0];
            acc_op_i    = o[1:0];
            #1;
            if (a <= 1)      check("R7 main/backup grant", acc_grant_o, grant_ref(i, c[0], a, o));
            else if (a == 2) check("R8 option grant", acc_grant_o, grant_ref(i, c[0], a, o));
            else             check("R9 otp grant", acc_grant_o, grant_ref(i, c[0], a, o));
          end
      @(negedge clk_i);
    end
  endtask

  initial begin
    rst_ni = 1'b0; opt_byte_i = 8'h00; chg_req_i = 1'b0; chg_byte_i = 8'h00;
    erase_done_i = 1'b0; ctx_flash_i = 1'b0; acc_area_i = 2'd0; acc_op_i = 2'd0;
    t_decode();
    t_lock_refuse();
    t_raise();
    t_erase();
    t_grants();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule